// File: doc/BRIEF.md
# Accumulative Padding Detector

This block follows a multi-part hash request stream in which software appends its own message padding. It decides, request by request, which request carries the final padding. The block does not trust a descriptor's end flag for this. It judges each request by its content: the bit count in the request's final eight bytes, and a marker byte that must sit where padding begins.

For every accepted request the block adds the request length to a running byte total. It turns the trailing 64-bit big-endian value into a byte count and works out where padding would start. It then reads that one byte through a read port with one cycle of latency. The decision comes out as a one-cycle result strobe.

On a match the block reports:
- the padding offset, which is where the current request should be cut;
- the true message length.

It then clears both its running total and its cached-segment count. On a miss the request is counted as one more cached segment. Hashing and segment storage are handled by neighbouring logic.

Top module: `acc_pad_detect`

## Requirements
- R1: Reset clears the running total and the cached count. While reset is held and after it is released, `res_valid`, `rd_en`, `has_padding`, `pad_offset`, `msg_length` and `cached_count` are all zero.
- R2: The running total grows by `req_len` for every accepted request, and the addition happens before that request is judged. The total is kept across non-padding requests.
- R3: The candidate message length is `req_tail` floor-divided by 8. `req_tail[63:56]` is the earliest byte of the request's final eight. The comparison uses all 64 bits of `req_tail`, so set high bits always make the candidate implausible.
- R4: A candidate larger than the updated running total yields no padding.
- R5: The padding size is the total minus the candidate, and the offset is `req_len` minus the padding size. If the padding size is zero or larger than `req_len`, the result is no padding and no byte read is issued.
- R6: For a plausible candidate, `rd_en` is high for exactly the cycle after the acceptance edge, with `rd_addr` set to the offset. `rd_data` is taken one cycle later.
- R7: Padding is confirmed only when the byte read back equals 0x80.
- R8: On confirmation the result reports:
  - `has_padding`=1;
  - `pad_offset`= the offset;
  - `msg_length`= the candidate;
  - `cached_count`=0.

  The running total returns to zero.
- R9: Without confirmation the result reports `has_padding`=0, with `pad_offset` and `msg_length` at zero. `cached_count` rises by one and saturates at its all-ones value.
- R10: `res_valid` is high for exactly one cycle. That cycle starts at the third rising edge, counting the acceptance edge as the first.
- R11: A request presented in the two cycles after an acceptance edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_len | input | LEN_W | Request length in bytes |
| req_tail | input | 64 | Final eight request bytes, big-endian |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | LEN_W | Byte offset into the request |
| rd_data | input | 8 | Byte returned one cycle after `rd_en` |
| res_valid | output | 1 | Result strobe |
| has_padding | output | 1 | Request holds the final padding |
| pad_offset | output | LEN_W | Byte offset where padding starts |
| msg_length | output | TOT_W | True message length in bytes |
| cached_count | output | CNT_W | Cached segments after this request |

## Verification
A corrupted running total shows up no later than the next padding request. That request reports a miss, or a wrong offset and length, because every padding decision depends on the accumulated bytes. A wrong cached count shows in the very result strobe that follows it. A mistimed read shows as a miss, because the marker byte is only present at the correct offset. Stray or stretched strobes appear within a cycle of the result.

// File: rtl/acc_pad_detect.sv
module acc_pad_detect #(
  parameter int LEN_W = 28,
  parameter int TOT_W = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [63:0]      req_tail,
  output logic             rd_en,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             res_valid,
  output logic             has_padding,
  output logic [LEN_W-1:0] pad_offset,
  output logic [TOT_W-1:0] msg_length,
  output logic [CNT_W-1:0] cached_count
);
  localparam logic [7:0]       PAD_MARK = 8'h80;
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK} state_t;

  state_t           state;
  logic [TOT_W-1:0] total_q, cand_q;
  logic             cand_ok_q;

  logic             accept, in_range, hit;
  logic [TOT_W-1:0] len_ext, sum, pad_size;
  logic [63:0]      cand_wide;
  logic [LEN_W-1:0] offset;

  assign accept    = req_valid && (state == ST_IDLE);
  assign len_ext   = TOT_W'(req_len);
  assign sum       = total_q + len_ext;
  assign cand_wide = {3'b000, req_tail[63:3]};
  assign pad_size  = sum - cand_wide[TOT_W-1:0];
  assign offset    = req_len - LEN_W'(pad_size);
  assign in_range  = (cand_wide <= 64'(sum)) && (pad_size != '0) && (pad_size <= len_ext);
  assign hit       = cand_ok_q && (rd_data == PAD_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      total_q      <= '0;
      cand_q       <= '0;
      cand_ok_q    <= 1'b0;
      rd_en        <= 1'b0;
      rd_addr      <= '0;
      res_valid    <= 1'b0;
      has_padding  <= 1'b0;
      pad_offset   <= '0;
      msg_length   <= '0;
      cached_count <= '0;
    end else begin
      res_valid <= 1'b0;
      rd_en     <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          total_q   <= sum;
          cand_q    <= cand_wide[TOT_W-1:0];
          cand_ok_q <= in_range;
          rd_en     <= in_range;
          rd_addr   <= offset;
          state     <= ST_READ;
        end
        ST_READ: state <= ST_CHECK;
        ST_CHECK: begin
          res_valid   <= 1'b1;
          has_padding <= hit;
          pad_offset  <= hit ? rd_addr : '0;
          msg_length  <= hit ? cand_q : '0;
          if (hit) begin
            total_q      <= '0;
            cached_count <= '0;
          end else if (cached_count != CNT_TOP) begin
            cached_count <= cached_count + 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $past(accept));
  a_r6_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  a_r5_offset_inside: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr < $past(req_len));
  a_r10_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 res_valid);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r7_marker_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && has_padding) |-> ($past(rd_data) == PAD_MARK) && $past(rd_en, 2));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !has_padding) |->
      (cached_count == $past(cached_count) + CNT_W'(1)) || (cached_count == CNT_TOP));
  a_r8_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && has_padding) |-> (cached_count == '0));
endmodule

// File: tb/sim_acc_pad_detect.sv
module sim_acc_pad_detect;
  localparam int LEN_W = 28;
  localparam int TOT_W = 32;
  localparam int CNT_W = 8;

  typedef struct packed {
    int          len;
    logic [63:0] tail;
    int          mark;
    int          hit;
    int          off;
    int          msg;
    int          cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{20, 64'd0,        -1, 0,  0,   0, 1},  // R2 R5 accumulate, wrong byte
    '{16, 64'd240,      10, 1, 10,  30, 0},  // R2 R8 two-part message
    '{64, 64'd8000,      5, 0,  0,   0, 1},  // R4 candidate too large
    '{ 8, 64'd80,        0, 0,  0,   0, 2},  // R5 negative offset
    '{32, 64'd832,       0, 0,  0,   0, 3},  // R5 offset at end
    '{24, 64'd960,      16, 1, 16, 120, 0},  // R8 four-part message
    '{40, 64'd72,        8, 0,  0,   0, 1},  // R7 marker misplaced
    '{12, 64'd320,       0, 1,  0,  40, 0},  // R8 offset zero
    '{48, 64'd240,      30, 1, 30,  30, 0},  // R8 single request
    '{16, 64'd47,        5, 1,  5,   5, 0},  // R3 floor divide
    '{10, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 1},  // R3 full-width compare
    '{ 6, 64'd112,       4, 1,  4,  14, 0}   // R2 R8 after wide miss
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [63:0]      req_tail = '0;
  logic             rd_en;
  logic [LEN_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             res_valid, has_padding;
  logic [LEN_W-1:0] pad_offset;
  logic [TOT_W-1:0] msg_length;
  logic [CNT_W-1:0] cached_count;
  logic [7:0]       mem [0:255];

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  acc_pad_detect #(.LEN_W(LEN_W), .TOT_W(TOT_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_tail(req_tail), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .res_valid(res_valid), .has_padding(has_padding), .pad_offset(pad_offset),
    .msg_length(msg_length), .cached_count(cached_count));

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[7:0]];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int mark);
    for (int k = 0; k < 256; k++) mem[k] = 8'h11;
    if (mark >= 0) mem[mark] = 8'h80;
  endtask

  task automatic run_req(input string tag, input int len, input logic [63:0] tail,
                         input int mark, input int hit, input int off,
                         input int msg, input int cnt);
    @(negedge clk);
    fill(mark);
    req_len   = LEN_W'(len);
    req_tail  = tail;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit != 0) begin
      chk({tag, " R6 rd_en"}, 64'(rd_en), 64'd1);
      chk({tag, " R6 rd_addr"}, 64'(rd_addr), 64'(off));
    end
    @(negedge clk);
    chk({tag, " R10 early strobe"}, 64'(res_valid), 64'd0);
    @(negedge clk);
    chk({tag, " R10 res_valid"}, 64'(res_valid), 64'd1);
    chk({tag, " R7 R8 has_padding"}, 64'(has_padding), 64'(hit));
    chk({tag, " R8 R9 pad_offset"}, 64'(pad_offset), 64'(off));
    chk({tag, " R8 R9 msg_length"}, 64'(msg_length), 64'(msg));
    chk({tag, " R8 R9 cached_count"}, 64'(cached_count), 64'(cnt));
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fill(-1);
    repeat (3) @(negedge clk);
    chk("R1 res_valid in reset", 64'(res_valid), 64'd0);
    chk("R1 rd_en in reset", 64'(rd_en), 64'd0);
    chk("R1 outputs in reset",
        64'(has_padding) | 64'(pad_offset) | 64'(msg_length) | 64'(cached_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid after reset", 64'(res_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_req($sformatf("vec%0d", i), VECS[i].len, VECS[i].tail, VECS[i].mark,
              VECS[i].hit, VECS[i].off, VECS[i].msg, VECS[i].cnt);
    end

    // R10: strobe lasts one cycle
    @(negedge clk);
    chk("R10 strobe width", 64'(res_valid), 64'd0);

    // R11: requests during evaluation are ignored
    @(negedge clk);
    fill(-1);
    req_len = LEN_W'(20); req_tail = 64'd0; req_valid = 1'b1;
    @(negedge clk);
    req_len = LEN_W'(50);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 first result", 64'(res_valid), 64'd1);
    chk("R11 first count", 64'(cached_count), 64'd1);
    @(negedge clk);
    chk("R11 no second result", 64'(res_valid), 64'd0);
    run_req("R11 total kept", 16, 64'd240, 10, 1, 10, 30, 0);

    // R9: saturation of the cached count
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      fill(-1);
      req_len = LEN_W'(1); req_tail = 64'hFFFF_FFFF_FFFF_FFFF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (i == 254) chk("R9 count reaches top", 64'(cached_count), 64'd255);
      if (i == 255) chk("R9 count saturates", 64'(cached_count), 64'd255);
    end

    // R1: reset mid-accumulation clears the running total and the count
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 count cleared", 64'(cached_count), 64'd0);
    rst_n = 1'b1;
    run_req("R1 total cleared", 48, 64'd240, 30, 1, 30, 30, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule